// File: doc/BRIEF.md
# Extended Divide Unit with Flags

This block is a multi-cycle sequential divider serving three divide operations of a 16-bit register machine: a 32-by-16 unsigned divide and a 32-by-16 signed divide, both taking the dividend from the concatenation of the Y and D registers and the divisor from X, plus a 16-by-16 signed divide that takes its dividend from D alone and its divisor from X. It returns a quotient, a remainder, four condition flags, and a write enable for each register and each flag. The surrounding register file stores the values; this block only computes them.

An operation starts with a one-cycle `start` pulse that carries the operation code and the three operand values. The unit turns signed operands into magnitudes and runs a restoring shift-subtract loop that produces one quotient bit per clock. It then corrects the signs, forms the flags, and raises `done` for one cycle together with the enables. When the divisor is zero, only the carry flag is written.

Top module: `xdiv_unit`

## Requirements
- R1: After reset, `busy` and `done` are low. Every register write enable and every flag write enable stays low in all cycles where `done` is low.
- R2: An accepted `start` (sampled while `busy` is low) raises `done` exactly 2·W+1 clock edges later (33 for W=16). `done` lasts one cycle, and `busy` falls in that same cycle.
- R3: A `start` sampled while `busy` is high has no effect: the running operation's results are unchanged and no extra `done` pulse follows.
- R4: Operation code 2'b00 is the unsigned divide of {Y,D} by X. The low W quotient bits go to `quo_out` with `y_we`, and the remainder goes to `rem_out` with `d_we`. `x_we` stays low.
- R5: Operation code 2'b01 is the signed divide of {Y,D} by X, with quotient to Y and remainder to D. The quotient truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R6: Operation codes 2'b10 and 2'b11 are the signed divide of D by X. The quotient goes to `quo_out` with `x_we`, the remainder goes to D, and `y_in` has no effect on the result.
- R7: With a zero divisor, `flg_we` is 4'b0001, `flg_out[0]` (C) is 1, and `y_we`, `x_we` and `d_we` stay low.
- R8: With a nonzero divisor, `flg_we` is 4'b1111 and C (bit 0) is 0. Z (bit 2) is 1 exactly when the full-width quotient is zero. N (bit 3) is bit W-1 of the written quotient.
- R9: For the unsigned divide, V (bit 1) is 1 when any of the upper W bits of the full quotient is nonzero.
- R10: For both signed divides, V is 1 when the quotient lies outside -2^(W-1) to 2^(W-1)-1. One case is -32768 divided by -1 in the short divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only while idle |
| op | input | 2 | Operation code (see R4 to R6) |
| y_in | input | W | Upper dividend half |
| d_in | input | W | Lower dividend half, or the whole dividend for the short divide |
| x_in | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quo_out | output | W | Quotient, low W bits |
| rem_out | output | W | Remainder |
| y_we | output | 1 | Write quotient into Y |
| x_we | output | 1 | Write quotient into X |
| d_we | output | 1 | Write remainder into D |
| flg_out | output | 4 | Flag values {N,Z,V,C} |
| flg_we | output | 4 | Per-flag write enables, same bit order |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. `busy` drops on the edge that raises `done`, so a `start` held during the `done` cycle is taken on the following edge. The bench issues every operation back to back, driving the next start during the previous `done` cycle. It then checks that the old `done` lasted one cycle, that the new operation's latency is exact, and that its results match the reference function. A start pulsed mid-run is also checked to leave the results untouched and to produce no further `done`.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;
  localparam logic [1:0] OP_UWIDE = 2'b00;
  localparam logic [1:0] OP_SWIDE = 2'b01;

  function automatic logic op_is_signed(input logic [1:0] op);
    return op != OP_UWIDE;
  endfunction

  function automatic logic op_is_short(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/xdiv_prep.sv
module xdiv_prep import xdiv_pkg::*; #(
  parameter int W = 16
) (
  input  logic [1:0]     op,
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] mag_dvd,
  output logic [W-1:0]   mag_dvs,
  output logic           neg_dvd,
  output logic           neg_q,
  output logic           dvs_zero
);
  logic [2*W-1:0] dvd_raw;
  logic           neg_dvs;

  always_comb begin
    dvd_raw  = op_is_short(op) ? {{W{lo[W-1]}}, lo} : {hi, lo};
    neg_dvd  = op_is_signed(op) & dvd_raw[2*W-1];
    neg_dvs  = op_is_signed(op) & dvs[W-1];
    mag_dvd  = neg_dvd ? -dvd_raw : dvd_raw;
    mag_dvs  = neg_dvs ? -dvs : dvs;
    neg_q    = neg_dvd ^ neg_dvs;
    dvs_zero = (dvs == '0);
  end
endmodule

// File: rtl/xdiv_step.sv
module xdiv_step #(
  parameter int W = 16
) (
  input  logic [W-1:0]   rem,
  input  logic [2*W-1:0] quo,
  input  logic [W-1:0]   dvs,
  output logic [W-1:0]   rem_n,
  output logic [2*W-1:0] quo_n
);
  logic [W:0] shifted;
  logic [W:0] trial;
  logic       fits;

  always_comb begin
    shifted = {rem, quo[2*W-1]};
    trial   = shifted - {1'b0, dvs};
    fits    = ~trial[W];
    rem_n   = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_n   = {quo[2*W-2:0], fits};
  end
endmodule

// File: rtl/xdiv_fix.sv
module xdiv_fix import xdiv_pkg::*; #(
  parameter int W = 16
) (
  input  logic [1:0]     op,
  input  logic [2*W-1:0] mag_q,
  input  logic [W-1:0]   mag_r,
  input  logic           neg_q,
  input  logic           neg_r,
  output logic [W-1:0]   q_w,
  output logic [W-1:0]   r_w,
  output logic           zf,
  output logic           nf,
  output logic           vf
);
  localparam logic [2*W-1:0] LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  always_comb begin
    q_w = neg_q ? -mag_q[W-1:0] : mag_q[W-1:0];
    r_w = neg_r ? -mag_r : mag_r;
    zf  = (mag_q == '0);
    nf  = q_w[W-1];
    if (op_is_signed(op))
      vf = neg_q ? (mag_q > LIM) : (mag_q >= LIM);
    else
      vf = |mag_q[2*W-1:W];
  end
endmodule

// File: rtl/xdiv_unit.sv
module xdiv_unit import xdiv_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] x_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out,
  output logic         y_we,
  output logic         x_we,
  output logic         d_we,
  output logic [3:0]   flg_out,
  output logic [3:0]   flg_we
);
  localparam int STEPS = 2 * W;
  localparam int CW    = $clog2(STEPS + 1);

  logic [CW-1:0]  cnt;
  logic [1:0]     op_q;
  logic [W-1:0]   rem_q, dvs_q;
  logic [2*W-1:0] quo_q;
  logic           negq_q, negr_q, dz_q;

  logic [2*W-1:0] p_dvd;
  logic [W-1:0]   p_dvs;
  logic           p_negd, p_negq, p_zero;
  logic [W-1:0]   s_rem;
  logic [2*W-1:0] s_quo;
  logic [W-1:0]   f_q, f_r;
  logic           f_z, f_n, f_v;

  xdiv_prep #(.W(W)) u_prep (
    .op(op), .hi(y_in), .lo(d_in), .dvs(x_in),
    .mag_dvd(p_dvd), .mag_dvs(p_dvs), .neg_dvd(p_negd),
    .neg_q(p_negq), .dvs_zero(p_zero)
  );

  xdiv_step #(.W(W)) u_step (
    .rem(rem_q), .quo(quo_q), .dvs(dvs_q),
    .rem_n(s_rem), .quo_n(s_quo)
  );

  xdiv_fix #(.W(W)) u_fix (
    .op(op_q), .mag_q(quo_q), .mag_r(rem_q),
    .neg_q(negq_q), .neg_r(negr_q),
    .q_w(f_q), .r_w(f_r), .zf(f_z), .nf(f_n), .vf(f_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      op_q    <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      dz_q    <= 1'b0;
      quo_out <= '0;
      rem_out <= '0;
      y_we    <= 1'b0;
      x_we    <= 1'b0;
      d_we    <= 1'b0;
      flg_out <= '0;
      flg_we  <= '0;
    end else begin
      done   <= 1'b0;
      y_we   <= 1'b0;
      x_we   <= 1'b0;
      d_we   <= 1'b0;
      flg_we <= '0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          op_q   <= op;
          rem_q  <= '0;
          quo_q  <= p_dvd;
          dvs_q  <= p_dvs;
          negq_q <= p_negq;
          negr_q <= p_negd;
          dz_q   <= p_zero;
        end
      end else if (cnt != CW'(STEPS)) begin
        rem_q <= s_rem;
        quo_q <= s_quo;
        cnt   <= cnt + 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        if (dz_q) begin
          flg_we  <= 4'b0001;
          flg_out <= {flg_out[3:1], 1'b1};
        end else begin
          flg_we  <= 4'b1111;
          flg_out <= {f_n, f_z, f_v, 1'b0};
          quo_out <= f_q;
          rem_out <= f_r;
          d_we    <= 1'b1;
          if (op_is_short(op_q)) x_we <= 1'b1;
          else                   y_we <= 1'b1;
        end
      end
    end
  end

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!y_we && !x_we && !d_we && flg_we == 4'b0000)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != CW'(STEPS)) |=> (busy && !done)); // R3

  AST_ONE_QUOTIENT_DEST: assert property (@(posedge clk) disable iff (rst)
    done |-> !(y_we && x_we)); // R4

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (rst)
    (done && d_we && op_is_signed(op_q) && rem_out != '0) |-> (rem_out[W-1] == negr_q)); // R5

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (done && !flg_we[2]) |-> (flg_we == 4'b0001 && flg_out[0] && !y_we && !x_we && !d_we)); // R7

  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done && flg_we[2]) |-> (!flg_out[0] && d_we)); // R8
endmodule

// File: tb/xdiv_unit_test.sv
`timescale 1ns/1ps
module xdiv_unit_test;
  localparam int W = 16;
  localparam int LAT = 2 * W + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] y_in = '0, d_in = '0, x_in = '0;
  logic         busy, done, y_we, x_we, d_we;
  logic [W-1:0] quo_out, rem_out;
  logic [3:0]   flg_out, flg_we;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xdiv_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .y_in(y_in), .d_in(d_in), .x_in(x_in),
    .busy(busy), .done(done), .quo_out(quo_out), .rem_out(rem_out),
    .y_we(y_we), .x_we(x_we), .d_we(d_we),
    .flg_out(flg_out), .flg_we(flg_we)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] o, input logic [15:0] y, d, x,
                       output bit dz, output logic [15:0] q, r,
                       output bit z, n, v);
    longint a, b, qq, rr;
    dz = (x == 16'd0);
    q = '0; r = '0; z = 0; n = 0; v = 0;
    if (!dz) begin
      if (o == 2'b00) begin
        a = {32'd0, y, d};
        b = {48'd0, x};
      end else if (o == 2'b01) begin
        a = longint'($signed({y, d}));
        b = longint'($signed(x));
      end else begin
        a = longint'($signed(d));
        b = longint'($signed(x));
      end
      qq = a / b;
      rr = a % b;
      q = qq[15:0];
      r = rr[15:0];
      z = (qq == 0);
      n = qq[15];
      v = (o == 2'b00) ? (qq > 65535) : (qq > 32767 || qq < -32768);
    end
  endtask

  // Drives start at the current negedge; returns at the negedge where done is seen.
  task automatic issue(input logic [1:0] o, input logic [15:0] y, d, x, input bit poke);
    bit dz, z, n, v;
    logic [15:0] q, r;
    int cycles;
    model(o, y, d, x, dz, q, r, z, n, v);
    start = 1'b1; op = o; y_in = y; d_in = d; x_in = x;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R2 done lasts one cycle", done, 0);
    cycles = 0;
    while (!done && cycles < 100) begin
      if (poke && cycles == 5) begin
        chk(busy, "R3 busy mid-run", busy, 1);
        start = 1'b1; op = ~o; y_in = ~y; d_in = ~d; x_in = x + 16'd3;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cycles == LAT, "R2 latency", cycles, LAT);
    chk(!busy, "R2 busy low at done", busy, 0);
    if (dz) begin
      chk(flg_we == 4'b0001, "R7 flag mask", flg_we, 1);
      chk(flg_out[0], "R7 carry set", flg_out[0], 1);
      chk(!y_we && !x_we && !d_we, "R7 no register write", {y_we, x_we, d_we}, 0);
    end else begin
      chk(d_we, "R4 remainder enable", d_we, 1);
      if (o[1]) begin
        chk(x_we && !y_we, "R6 quotient to X", {y_we, x_we}, 1);
        chk(quo_out == q, "R6 quotient", quo_out, q);
        chk(rem_out == r, "R6 remainder", rem_out, r);
      end else if (o == 2'b01) begin
        chk(y_we && !x_we, "R5 quotient to Y", {y_we, x_we}, 2);
        chk(quo_out == q, "R5 quotient", quo_out, q);
        chk(rem_out == r, "R5 remainder", rem_out, r);
      end else begin
        chk(y_we && !x_we, "R4 quotient to Y", {y_we, x_we}, 2);
        chk(quo_out == q, "R4 quotient", quo_out, q);
        chk(rem_out == r, "R4 remainder", rem_out, r);
      end
      chk(flg_we == 4'b1111, "R8 flag mask", flg_we, 15);
      chk(flg_out[0] == 1'b0, "R8 carry clear", flg_out[0], 0);
      chk(flg_out[2] == z, "R8 zero flag", flg_out[2], z);
      chk(flg_out[3] == n, "R8 negative flag", flg_out[3], n);
      if (o == 2'b00) chk(flg_out[1] == v, "R9 unsigned overflow", flg_out[1], v);
      else            chk(flg_out[1] == v, "R10 signed overflow", flg_out[1], v);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int extra;
    logic [15:0] rx;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done, "R1 reset state", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !y_we && !x_we && !d_we && flg_we == 0,
        "R1 idle after reset", {busy, done, y_we, x_we, d_we, flg_we}, 0);

    // directed corners
    issue(2'b00, 16'h0000, 16'h0064, 16'h0007, 0);
    issue(2'b00, 16'h0001, 16'h0000, 16'h0001, 0);   // R9 V with zero low half
    issue(2'b00, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
    issue(2'b00, 16'h0000, 16'h0003, 16'h0009, 0);   // zero quotient
    issue(2'b01, 16'hFFFF, 16'hFFF9, 16'h0002, 0);   // -7/2 R5
    issue(2'b01, 16'h0000, 16'h0007, 16'hFFFE, 0);   // 7/-2 R5
    issue(2'b01, 16'h8000, 16'h0000, 16'hFFFF, 0);   // R10 wide overflow
    issue(2'b01, 16'hFFFF, 16'h8000, 16'h0001, 0);   // -32768 exact, no V
    issue(2'b10, 16'h1234, 16'h8000, 16'hFFFF, 0);   // R10 short overflow
    issue(2'b11, 16'hABCD, 16'hFF9C, 16'h0007, 0);   // R6 y ignored
    issue(2'b10, 16'h0000, 16'h0000, 16'h0005, 0);
    issue(2'b00, 16'h1234, 16'h5678, 16'h0000, 0);   // R7 each op
    issue(2'b01, 16'h8765, 16'h4321, 16'h0000, 0);
    issue(2'b10, 16'h0000, 16'h7FFF, 16'h0000, 0);
    issue(2'b01, 16'h0012, 16'h3456, 16'h0789, 1);   // R3 mid-run start

    // R3: no further done after the poked run
    @(negedge clk);
    extra = 0;
    for (int i = 0; i < LAT + 8; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R3 no extra done", extra, 0);

    // constrained random, back to back
    for (int i = 0; i < 200; i++) begin
      case ($urandom % 8)
        0:       rx = 16'h0000;
        1, 2:    rx = 16'($urandom % 16);
        3:       rx = 16'hFFFF - 16'($urandom % 4);
        default: rx = 16'($urandom);
      endcase
      issue(2'($urandom), 16'($urandom), 16'($urandom), rx, (i % 37) == 3);
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule